// File: doc/BRIEF.md
# Overlapped-Grant Bus Arbiter

This block decides which of several masters owns a shared bus. Each master pulls its own active-low request line. The arbiter answers on a matching active-low grant line. At most one master holds a grant at any time. The winner is chosen by priority. By default priority is fixed by index, and a build option rotates it after each finished transaction.

The arbiter does not wait for the bus to go quiet before it moves the grant. While one master is still driving a transaction, the arbiter can take the grant away from it and give it to the next master after one empty cycle. The new owner then begins its address phase on the first cycle in which it sees its grant and an idle bus. Arbitration therefore costs no bus cycles.

The arbiter watches the cycle-framing and initiator-ready lines. From them it detects when a transaction starts and when it ends, and uses those events to advance the rotating priority.

Top module: `bus_arbiter`

## Requirements
- R1: Request bit i low means master i requests the bus. Grant bit i low means master i is granted. While reset is held, and in the first cycle after it, every grant bit is high.
- R2: No more than one grant bit is low in any cycle.
- R3: If no grant is held and at least one request is present, the winning master is granted in the next cycle.
- R4: In fixed mode, the lowest-numbered requesting master wins.
- R5: In rotating mode, the search starts one index above the master whose transaction last completed, wrapping past the highest index. A transaction completes when the bus returns to idle. Before any transaction has completed, the search starts at index 0.
- R6: The grant can pass to a new master while the current transaction is still on the bus. The arbiter does not wait for the bus to be idle.
- R7: A grant never moves straight from one master to another. Between two different grantees there is at least one cycle in which every grant bit is high.
- R8: If the granted master is no longer requesting, its grant is removed in the next cycle. This applies whether or not it has started a transaction.
- R9: A granted master keeps its grant while it still requests and is still the winner, including during and after its own transaction.
- R10: The bus is idle when the framing and ready lines are both high. A transaction starts when the framing line goes low after an idle cycle while a grant is held. It ends on the first idle cycle after a busy one.
- R11: When no request is present, every grant bit is high in the next cycle. Grants are never parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | N_MASTERS | Per-master request, active low |
| frame_ni | input | 1 | Transaction framing line, active low |
| irdy_ni | input | 1 | Initiator-ready line, active low |
| gnt_no | output | N_MASTERS | Per-master grant, active low |

## Verification
The bench builds two copies with N_MASTERS set to 4: one with fixed priority and one with rotating priority.

The fixed copy covers several cases:
- the choice among simultaneous requests;
- a request withdrawn before the master starts;
- a grant taken away by a higher-priority newcomer;
- the hand-over of the grant to a second master while the first master's transaction keeps the bus busy.

The rotating copy runs two back-to-back transactions. They show the pointer advancing past the owner even though a lower-numbered master is still asking.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_bus_mon.sv
module arb_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  output logic idle_o,
  output logic start_o,
  output logic end_o
);
  logic idle_prev_q;

  assign idle_o  = frame_ni & irdy_ni;
  assign start_o = ~frame_ni & idle_prev_q;
  assign end_o   = idle_o & ~idle_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_prev_q <= 1'b1;
    else         idle_prev_q <= idle_o;
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [IDX_W-1:0]     base_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  int p;

  // walk downward so the nearest index to base_i is assigned last
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    p       = 0;
    for (int k = N_MASTERS - 1; k >= 0; k--) begin
      p = (int'(base_i) + k) % N_MASTERS;
      if (req_i[p]) begin
        valid_o = 1'b1;
        idx_o   = p[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] vec_i,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int                 N_MASTERS = 4,
  parameter arb_pkg::arb_mode_e MODE      = arb_pkg::ARB_FIXED
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_ni,
  input  logic                 frame_ni,
  input  logic                 irdy_ni,
  output logic [N_MASTERS-1:0] gnt_no
);
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MASTERS - 1);

  logic [N_MASTERS-1:0] req, gnt_q, gnt_d;
  logic [IDX_W-1:0]     win_idx, gnt_idx, owner_q, ptr_q, search_base;
  logic                 win_valid, keep, owner_vld_q;
  logic                 bus_idle, start_evt, end_evt;

  assign req    = ~req_ni;
  assign gnt_no = ~gnt_q;

  arb_bus_mon u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_ni(frame_ni),
    .irdy_ni (irdy_ni),
    .idle_o  (bus_idle),
    .start_o (start_evt),
    .end_o   (end_evt)
  );

  arb_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req_i  (req),
    .base_i (search_base),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  arb_onehot_enc #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_enc (
    .vec_i(gnt_q),
    .idx_o(gnt_idx)
  );

  // grant survives only while its holder remains the winner; any change goes through all-idle
  assign keep = (gnt_q != '0) && win_valid && gnt_q[win_idx];

  always_comb begin
    if (gnt_q == '0) gnt_d = win_valid ? (N_MASTERS'(1) << win_idx) : '0;
    else             gnt_d = keep ? gnt_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  // owner of the transaction on the bus, for rotation on completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q     <= '0;
      owner_vld_q <= 1'b0;
      ptr_q       <= '0;
    end else begin
      if (start_evt && (gnt_q != '0)) begin
        owner_q     <= gnt_idx;
        owner_vld_q <= 1'b1;
      end else if (end_evt) begin
        owner_vld_q <= 1'b0;
      end
      if (end_evt && owner_vld_q)
        ptr_q <= (owner_q == LAST_IDX) ? '0 : owner_q + 1'b1;
    end
  end

  if (MODE == arb_pkg::ARB_ROTATE) begin : g_rotate
    assign search_base = ptr_q;
  end else begin : g_fixed
    logic unused_ptr;
    assign search_base = '0;
    assign unused_ptr  = ^{ptr_q, bus_idle};
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)) else $error("R2 multiple grants");

  assert_gnt_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0) |=> (gnt_q == '0) || (gnt_q == $past(gnt_q)))
    else $error("R7 grant moved without gap");

  assert_idle_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q == '0) && (req != '0)) |=> (gnt_q != '0))
    else $error("R3 pending request not granted");

  assert_drop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q != '0) && ((gnt_q & req) == '0)) |=> (gnt_q == '0))
    else $error("R8 grant kept by non-requester");

  assert_no_req_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req == '0) |=> (gnt_q == '0)) else $error("R11 grant parked");

  if (MODE == arb_pkg::ARB_FIXED) begin : g_fixed_chk
    assert_fixed_lowest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((gnt_q == '0) && (req != '0)) |=> (gnt_q == ($past(req) & (~$past(req) + 1'b1))))
      else $error("R4 not lowest requester");
  end
endmodule

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_f_n = 4'hF, req_r_n = 4'hF;
  logic       frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] gnt_f_n, gnt_r_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_arbiter #(.N_MASTERS(4), .MODE(arb_pkg::ARB_FIXED)) u_bus_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_f_n),
    .frame_ni(frame_n), .irdy_ni(irdy_n), .gnt_no(gnt_f_n));

  bus_arbiter #(.N_MASTERS(4), .MODE(arb_pkg::ARB_ROTATE)) u_bus_arbiter_rr (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_r_n),
    .frame_ni(frame_n), .irdy_ni(irdy_n), .gnt_no(gnt_r_n));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_f_n = 4'hF; req_r_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1;
    step();
    chk("R1 reset fixed", gnt_f_n, 4'hF);
    chk("R1 reset rotate", gnt_r_n, 4'hF);
    rst_n = 1'b1;
  endtask

  task automatic t_fixed();
    do_reset();
    req_f_n = ~4'b1010;
    step(); chk("R4 lowest of 1,3", gnt_f_n, ~4'b0010);
    step(); chk("R9 hold", gnt_f_n, ~4'b0010);
    req_f_n = ~4'b1000;
    step(); chk("R8 drop before start", gnt_f_n, 4'hF);
    step(); chk("R3 regrant", gnt_f_n, ~4'b1000);
    req_f_n = ~4'b1001;
    step(); chk("R7 gap on preempt", gnt_f_n, 4'hF);
    step(); chk("R4 master 0 wins", gnt_f_n, ~4'b0001);
    req_f_n = 4'hF;
    step(); chk("R11 release", gnt_f_n, 4'hF);
  endtask

  task automatic t_overlap();
    do_reset();
    req_f_n = ~4'b0100;
    step(); chk("R3 grant 2", gnt_f_n, ~4'b0100);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(); chk("R9 owner keeps grant", gnt_f_n, ~4'b0100);
    req_f_n = ~4'b0110;
    step(); chk("R7 gap while busy", gnt_f_n, 4'hF);
    step(); chk("R6 grant 1 while busy", gnt_f_n, ~4'b0010);
    step(); chk("R6 held while busy", gnt_f_n, ~4'b0010);
    frame_n = 1'b1;
    step(); chk("R6 held last data", gnt_f_n, ~4'b0010);
    irdy_n = 1'b1;
    step(); chk("R10 idle, grant 1", gnt_f_n, ~4'b0010);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(); chk("R9 new owner started", gnt_f_n, ~4'b0010);
    req_f_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1;
    step(); chk("R11 release", gnt_f_n, 4'hF);
  endtask

  task automatic t_rotate();
    do_reset();
    req_r_n = ~4'b0111;
    step(); chk("R5 first from 0", gnt_r_n, ~4'b0001);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(); chk("R9 owner 0 busy", gnt_r_n, ~4'b0001);
    frame_n = 1'b1;
    step(); chk("R9 owner 0 last", gnt_r_n, ~4'b0001);
    irdy_n = 1'b1;
    step(); chk("R10 end edge", gnt_r_n, ~4'b0001);
    step(); chk("R7 gap rotate", gnt_r_n, 4'hF);
    step(); chk("R5 rotate to 1", gnt_r_n, ~4'b0010);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(); chk("R9 owner 1 busy", gnt_r_n, ~4'b0010);
    frame_n = 1'b1; irdy_n = 1'b1;
    step(); chk("R10 end edge 1", gnt_r_n, ~4'b0010);
    step(); chk("R7 gap rotate 2", gnt_r_n, 4'hF);
    step(); chk("R5 rotate to 2", gnt_r_n, ~4'b0100);
    req_r_n = 4'hF;
    step(); chk("R11 release rotate", gnt_r_n, 4'hF);
  endtask

  initial begin
    t_fixed();
    t_overlap();
    t_rotate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule